// File: doc/BRIEF.md
# Serial Command Front End for a Quad Digital Potentiometer

This block is the serial slave that sits between a four-wire serial bus and the register bank of a four-channel digital potentiometer controller. The bus pins are brought into the system clock domain through a synchroniser, and SCK edges are detected there. Each frame opens with a CS fall. The block checks the first byte against a fixed device-type nibble and the two strapped address pins. It then decodes the second byte into an operation code, a register index and a pot index. Every command falls into one of three shapes: a two-byte transfer, a three-byte access, or an open-ended stream of wiper steps.

Requests for the register bank leave on a valid/ready channel. A request stays on the outputs without change until the bank takes it with `req_ready`. A new request that arrives while one is still waiting is dropped. The bank returns read data on a plain `rsp_valid` strobe, which the block always accepts. That byte is shifted out on SO, most significant bit first, on falling SCK edges. A HOLD pause freezes the frame without clearing it and turns SO off.

Top module: `dpot_spi_frontend`

## Requirements
- R1: The first byte after CS falls is accepted only if bits 7..4 equal `DEV_TYPE` (default 0101), bits 3..2 equal `dev_addr`, and bits 1..0 are 00. Any other value abandons the frame, and the frame then produces no request and no SO activity.
- R2: A request carries `req_op` = instruction bits 7..4, `req_reg` = bits 3..2 and `req_pot` = bits 1..0. `req_data` and `req_dir` are 0 unless a later requirement sets them.
- R3: The transfer opcodes 1101, 1110, 0001 and 1000 issue one request when CS rises, and only if exactly 16 bits were clocked in.
- R4: The write opcodes 1010 and 1100 issue one request when CS rises, and only if exactly 24 bits were clocked in. `req_data` is the third byte, received MSB first.
- R5: The read opcodes 1001 and 1011 issue a request as soon as the instruction byte is complete. The byte returned on `rsp_data` drives SO MSB first. The first bit appears at the SCK fall that follows the 16th rising edge, and each later bit at the next fall.
- R6: Instruction byte 0x51 issues no request. Its data phase returns `wip` in bit 0 and zeros in bits 7..1.
- R7: After opcode 0010, each SCK rise issues one step request with `req_data` = 0 and `req_dir` = SI. A 1 means one step toward the high end. A CS rise ends the stream and issues nothing.
- R8: `req_valid` and the request fields hold unchanged while `req_ready` is low. A request generated while one is still outstanding and not accepted in that cycle is dropped.
- R9: `so_oe` is 0 out of reset, whenever synchronised CS is high, and outside the data phase of a read or status frame.
- R10: HOLD low, taken while SCK is low, ignores SCK edges and forces `so_oe` to 0. HOLD high, again while SCK is low, resumes the frame at the bit where it stopped.
- R11: If CS is low when reset ends, no frame is accepted until CS has risen and then fallen again.
- R12: An undefined opcode, a frame cut short, or a frame with extra bits issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_si | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_hold_n | input | 1 | Active-low pause |
| dev_addr | input | 2 | Strapped device address |
| wip | input | 1 | Write-in-progress flag returned by status reads |
| so_data | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Register bank accepts the request |
| req_op | output | 4 | Operation code |
| req_reg | output | 2 | Register index |
| req_pot | output | 2 | Pot index |
| req_data | output | 8 | Write data |
| req_dir | output | 1 | Step direction, 1 = toward the high end |
| rsp_valid | input | 1 | Read data strobe from the bank |
| rsp_data | input | 8 | Read data |

## Verification
Two events can meet in one cycle: a new wiper step can arrive in the same cycle as an older request that is still stalled. The bench provokes this by holding `req_ready` low while it clocks three steps. It then expects exactly one handshake, carrying the first direction, and nothing from the later steps. A second overlap is a HOLD pause in the middle of a read data byte while SCK keeps toggling. That case is judged by `so_oe` staying low during the pause and by the reassembled byte coming out intact after the pause ends.

// File: rtl/dpot_fe_pkg.sv
package dpot_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_XFER,
    CLS_WRITE,
    CLS_READ,
    CLS_STATUS,
    CLS_STEP
  } cmd_cls_e;

  function automatic cmd_cls_e classify(input logic [BYTE_W-1:0] ins);
    cmd_cls_e c;
    case (ins[7:4])
      4'b1101, 4'b1110, 4'b0001, 4'b1000: c = CLS_XFER;
      4'b1010, 4'b1100:                   c = CLS_WRITE;
      4'b1001, 4'b1011:                   c = CLS_READ;
      4'b0010:                            c = CLS_STEP;
      4'b0101: c = (ins[3:0] == 4'b0001) ? CLS_STATUS : CLS_NONE;
      default:                            c = CLS_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dpot_fe_sync.sv
module dpot_fe_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dpot_fe_decode.sv
module dpot_fe_decode
  import dpot_fe_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic              cs_n_s,
  input  logic              hold_n_s,
  input  logic [SEL_W-1:0]  dev_addr,
  input  logic              wip,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [OP_W-1:0]   req_op,
  output logic [SEL_W-1:0]  req_reg,
  output logic [SEL_W-1:0]  req_pot,
  output logic [BYTE_W-1:0] req_data,
  output logic              req_dir,
  output logic              tx_arm,
  output logic              tx_fall,
  output logic              paused,
  output logic              stat_load,
  output logic [BYTE_W-1:0] stat_byte
);
  localparam int CNT_W = $clog2(3*BYTE_W + 2);
  localparam logic [CNT_W-1:0] C_MAX      = '1;
  localparam logic [CNT_W-1:0] C_ID_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_INS_LAST = CNT_W'(2*BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_INS_DONE = CNT_W'(2*BYTE_W);
  localparam logic [CNT_W-1:0] C_DAT_LAST = CNT_W'(3*BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_DAT_DONE = CNT_W'(3*BYTE_W);

  logic              sck_d, cs_d, alive, hold_act;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, instr, wdata, nxt;
  cmd_cls_e          cls, nxt_cls;
  logic sck_rise, sck_fall, cs_fall, cs_rise, bit_in, id_ok;
  logic              iss, iss_dir;
  logic [BYTE_W-1:0] iss_ins, iss_data;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = cs_d & ~cs_n_s;
  assign cs_rise  = ~cs_d & cs_n_s;
  assign bit_in   = sck_rise & alive & ~cs_n_s & ~hold_act;
  assign nxt      = {shreg[BYTE_W-2:0], si_s};
  assign nxt_cls  = classify(nxt);
  assign id_ok    = (nxt[7:4] == DEV_TYPE) && (nxt[3:2] == dev_addr) && (nxt[1:0] == 2'b00);

  always_comb begin
    iss      = 1'b0;
    iss_ins  = instr;
    iss_data = '0;
    iss_dir  = 1'b0;
    if (cs_rise && alive &&
        ((cls == CLS_XFER && bitcnt == C_INS_DONE) ||
         (cls == CLS_WRITE && bitcnt == C_DAT_DONE))) begin
      iss      = 1'b1;
      iss_data = (cls == CLS_WRITE) ? wdata : '0;
    end else if (bit_in && bitcnt == C_INS_LAST && nxt_cls == CLS_READ) begin
      iss     = 1'b1;
      iss_ins = nxt;
    end else if (bit_in && cls == CLS_STEP && bitcnt >= C_INS_DONE) begin
      iss     = 1'b1;
      iss_dir = si_s;
    end
  end

  assign stat_load = bit_in && (bitcnt == C_INS_LAST) && (nxt_cls == CLS_STATUS);
  assign stat_byte = {{(BYTE_W-1){1'b0}}, wip};
  assign tx_arm    = alive & ~cs_n_s & ((cls == CLS_READ) || (cls == CLS_STATUS)) &
                     (bitcnt >= C_INS_DONE);
  assign tx_fall   = sck_fall & alive & ~cs_n_s & ~hold_act;
  assign paused    = hold_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b0; alive <= 1'b0; hold_act <= 1'b0;
      bitcnt <= '0; shreg <= '0; instr <= '0; wdata <= '0; cls <= CLS_NONE;
      req_valid <= 1'b0; req_op <= '0; req_reg <= '0; req_pot <= '0;
      req_data <= '0; req_dir <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
      if (!sck_s) hold_act <= ~hold_n_s;

      if (cs_fall) begin
        alive  <= 1'b1;
        bitcnt <= '0;
        cls    <= CLS_NONE;
      end else if (cs_rise) begin
        alive <= 1'b0;
      end else if (bit_in) begin
        shreg <= nxt;
        if (bitcnt != C_MAX) bitcnt <= bitcnt + 1'b1;
        if (bitcnt == C_ID_LAST && !id_ok) alive <= 1'b0;
        if (bitcnt == C_INS_LAST) begin
          instr <= nxt;
          cls   <= nxt_cls;
          if (nxt_cls == CLS_NONE) alive <= 1'b0;
        end
        if (bitcnt == C_DAT_LAST) wdata <= nxt;
      end

      if (req_valid && req_ready) req_valid <= 1'b0;
      if (iss && (!req_valid || req_ready)) begin
        req_valid <= 1'b1;
        req_op    <= iss_ins[7:4];
        req_reg   <= iss_ins[3:2];
        req_pot   <= iss_ins[1:0];
        req_data  <= iss_data;
        req_dir   <= iss_dir;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid &&
    $stable({req_op, req_reg, req_pot, req_data, req_dir})); // R8

  AST_CS_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !alive); // R12

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act && !cs_n_s && !cs_d |=> $stable(bitcnt)); // R10
endmodule

// File: rtl/dpot_fe_tx.sv
module dpot_fe_tx
  import dpot_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_arm,
  input  logic              tx_fall,
  input  logic              paused,
  input  logic              stat_load,
  input  logic [BYTE_W-1:0] stat_byte,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              so_data,
  output logic              so_oe
);
  logic [BYTE_W-1:0] obuf;
  logic              so_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0; so_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      if (tx_arm && tx_fall) begin
        so_q <= obuf[BYTE_W-1];
        obuf <= {obuf[BYTE_W-2:0], 1'b0};
        oe_q <= 1'b1;
      end else if (stat_load) begin
        obuf <= stat_byte;
      end else if (rsp_valid) begin
        obuf <= rsp_data;
      end
      if (!tx_arm) oe_q <= 1'b0;
    end
  end

  assign so_oe   = oe_q & tx_arm & ~paused;
  assign so_data = so_q;

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(tx_fall)); // R5
endmodule

// File: rtl/dpot_spi_frontend.sv
module dpot_spi_frontend
  import dpot_fe_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic [SEL_W-1:0]  dev_addr,
  input  logic              wip,
  output logic              so_data,
  output logic              so_oe,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [OP_W-1:0]   req_op,
  output logic [SEL_W-1:0]  req_reg,
  output logic [SEL_W-1:0]  req_pot,
  output logic [BYTE_W-1:0] req_data,
  output logic              req_dir,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data
);
  localparam int PIN_W = 4;

  logic [PIN_W-1:0]  pins_s;
  logic              sck_s, si_s, cs_n_s, hold_n_s;
  logic              tx_arm, tx_fall, paused, stat_load;
  logic [BYTE_W-1:0] stat_byte;

  dpot_fe_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_hold_n, spi_cs_n, spi_si, spi_sck}),
    .q(pins_s)
  );
  assign {hold_n_s, cs_n_s, si_s, sck_s} = pins_s;

  dpot_fe_decode #(.DEV_TYPE(DEV_TYPE)) u_dec (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .si_s(si_s), .cs_n_s(cs_n_s),
    .hold_n_s(hold_n_s), .dev_addr(dev_addr), .wip(wip),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_reg(req_reg), .req_pot(req_pot), .req_data(req_data), .req_dir(req_dir),
    .tx_arm(tx_arm), .tx_fall(tx_fall), .paused(paused),
    .stat_load(stat_load), .stat_byte(stat_byte)
  );

  dpot_fe_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tx_arm(tx_arm), .tx_fall(tx_fall), .paused(paused),
    .stat_load(stat_load), .stat_byte(stat_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .so_data(so_data), .so_oe(so_oe)
  );

  AST_SO_OFF_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !so_oe); // R9
endmodule

// File: tb/sim_dpot_spi_frontend.sv
module sim_dpot_spi_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic wip = 1'b0;
  logic req_ready = 1'b1;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic so_data, so_oe, req_valid, req_dir;
  logic [3:0] req_op;
  logic [1:0] req_reg, req_pot;
  logic [7:0] req_data;

  int checks = 0;
  int fails = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  localparam logic [7:0] ID = 8'h58;

  always #10 clk = ~clk;

  dpot_spi_frontend u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_si(si), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .dev_addr(dev_addr), .wip(wip), .so_data(so_data),
    .so_oe(so_oe), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_reg(req_reg), .req_pot(req_pot), .req_data(req_data), .req_dir(req_dir),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference bank: compares every handshake with the expectation queue
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      logic [16:0] got, e;
      string t;
      got = {req_op, req_reg, req_pot, req_data, req_dir};
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected request", {15'b0, got}, 32'h0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, {15'b0, got}, {15'b0, e});
      end
      if (req_op == 4'h9 || req_op == 4'hB) begin
        rsp_valid <= 1'b1;
        rsp_data  <= {req_op, req_reg, req_pot} ^ 8'hC3;
      end
    end else rsp_valid <= 1'b0;
  end

  task automatic expect_req(input logic [7:0] ins, input logic [7:0] d, input logic dir, input string t);
    exp_q.push_back({ins, d, dir});
    tag_q.push_back(t);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic so_b, output logic oe_b);
    sck = 1'b0; si = b;
    wait_clk(8);
    so_b = so_data; oe_b = so_oe;
    sck = 1'b1;
    wait_clk(8);
  endtask

  task automatic send(input logic [31:0] v, input int n, output logic [31:0] got, output logic [31:0] oe);
    logic b, o;
    got = '0; oe = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_x(v[i], b, o);
      got[i] = b; oe[i] = o;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; wait_clk(8);
  endtask

  task automatic cs_hi();
    sck = 1'b0; wait_clk(8);
    cs_n = 1'b1; wait_clk(12);
  endtask

  task automatic drained(input string t);
    wait_clk(20);
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  task automatic pause_with_noise();
    sck = 1'b0; wait_clk(8);
    hold_n = 1'b0; wait_clk(8);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; si = 1'b1; wait_clk(8);
      chk(so_oe == 1'b0, "R10 so_oe off in pause", so_oe, 0);
      sck = 1'b0; wait_clk(8);
    end
    hold_n = 1'b1; wait_clk(8);
  endtask

  initial begin
    logic [31:0] g, o;
    wait_clk(3);
    chk(req_valid == 1'b0, "R9 reset req_valid", req_valid, 0);
    chk(so_oe == 1'b0, "R9 reset so_oe", so_oe, 0);
    rst_n = 1'b1;
    wait_clk(4);
    // R11: CS already low at reset release, frame must be ignored
    send({ID, 8'hA1, 8'h3C}, 24, g, o);
    cs_hi();
    drained("R11 no request before CS fall");

    // R4 write wiper, pot 1
    cs_lo(); send({ID, 8'hA1, 8'h3C}, 24, g, o);
    expect_req(8'hA1, 8'h3C, 1'b0, "R4 write wiper");
    cs_hi(); drained("R4 write wiper drained");

    // R4/R2 write data register reg1 pot2
    cs_lo(); send({ID, 8'hC6, 8'h5A}, 24, g, o);
    expect_req(8'hC6, 8'h5A, 1'b0, "R2 write data register fields");
    cs_hi(); drained("R4 write register drained");

    // R3 transfers, single and global
    cs_lo(); send({ID, 8'hD7}, 16, g, o);
    expect_req(8'hD7, 8'h00, 1'b0, "R3 transfer to wiper");
    cs_hi(); drained("R3 transfer drained");
    cs_lo(); send({ID, 8'h1C}, 16, g, o);
    expect_req(8'h1C, 8'h00, 1'b0, "R3 global transfer");
    cs_hi(); drained("R3 global drained");

    // R12 short and long frames
    cs_lo(); send({ID, 7'h70}, 15, g, o); cs_hi();
    drained("R12 short transfer ignored");
    cs_lo(); send({ID, 8'hE0, 1'b1}, 17, g, o); cs_hi();
    drained("R12 long transfer ignored");
    cs_lo(); send({ID, 8'hA1, 7'h11}, 23, g, o); cs_hi();
    drained("R12 short write ignored");

    // R1 identification mismatches
    cs_lo(); send({8'h54, 8'hA1, 8'h3C}, 24, g, o); cs_hi();
    drained("R1 wrong address ignored");
    cs_lo(); send({8'h68, 8'hA1, 8'h3C}, 24, g, o); cs_hi();
    drained("R1 wrong type ignored");
    cs_lo(); send({8'h59, 8'hB9, 8'h00}, 24, g, o);
    chk(o[7:0] == 8'h00, "R1 no SO after bad id", o[7:0], 0);
    cs_hi(); drained("R1 nonzero low bits ignored");

    // R12 undefined opcode
    cs_lo(); send({ID, 8'h30, 8'hFF}, 24, g, o); cs_hi();
    drained("R12 undefined opcode ignored");

    // R5 read data register reg2 pot1
    cs_lo();
    expect_req(8'hB9, 8'h00, 1'b0, "R5 read register request");
    send({ID, 8'hB9}, 16, g, o);
    send(32'h0, 8, g, o);
    chk(g[7:0] == (8'hB9 ^ 8'hC3), "R5 read register SO byte", g[7:0], 8'hB9 ^ 8'hC3);
    chk(o[7:0] == 8'hFF, "R5 SO enabled in data phase", o[7:0], 8'hFF);
    cs_hi();
    chk(so_oe == 1'b0, "R9 SO off after CS high", so_oe, 0);
    drained("R5 read drained");

    // R10 pause inside a read of wiper, pot 3
    cs_lo();
    expect_req(8'h93, 8'h00, 1'b0, "R10 read wiper request");
    send({ID, 8'h93}, 16, g, o);
    begin
      logic [31:0] g1, g2, o1, o2;
      logic [7:0] byte_got;
      send(32'h0, 3, g1, o1);
      pause_with_noise();
      send(32'h0, 5, g2, o2);
      byte_got = {g1[2:0], g2[4:0]};
      chk(byte_got == (8'h93 ^ 8'hC3), "R10 read byte across pause", byte_got, 8'h93 ^ 8'hC3);
    end
    cs_hi(); drained("R10 read drained");

    // R10 pause inside the instruction byte of a write
    cs_lo();
    send({ID, 4'hA}, 12, g, o);
    pause_with_noise();
    send({4'h1, 8'h77}, 12, g, o);
    expect_req(8'hA1, 8'h77, 1'b0, "R10 write resumed after pause");
    cs_hi(); drained("R10 write drained");

    // R6 status byte
    wip = 1'b1;
    cs_lo(); send({ID, 8'h51}, 16, g, o); send(32'h0, 8, g, o);
    chk(g[7:0] == 8'h01, "R6 status with wip set", g[7:0], 8'h01);
    cs_hi();
    wip = 1'b0;
    cs_lo(); send({ID, 8'h51}, 16, g, o); send(32'h0, 8, g, o);
    chk(g[7:0] == 8'h00, "R6 status with wip clear", g[7:0], 8'h00);
    cs_hi(); drained("R6 status issues no request");

    // R7 steps on pot 2
    cs_lo(); send({ID, 8'h22}, 16, g, o);
    expect_req(8'h22, 8'h00, 1'b1, "R7 step up");
    send(32'h1, 1, g, o); wait_clk(4);
    expect_req(8'h22, 8'h00, 1'b1, "R7 step up again");
    send(32'h1, 1, g, o); wait_clk(4);
    expect_req(8'h22, 8'h00, 1'b0, "R7 step down");
    send(32'h0, 1, g, o);
    cs_hi(); drained("R7 no request at CS rise");

    // R8 back-pressure: steps while stalled are dropped
    req_ready = 1'b0;
    cs_lo(); send({ID, 8'h23}, 16, g, o);
    send(32'h4, 3, g, o);
    wait_clk(4);
    chk(req_valid == 1'b1, "R8 request held while stalled", req_valid, 1);
    chk(req_dir == 1'b1, "R8 first step kept", req_dir, 1);
    cs_hi();
    expect_req(8'h23, 8'h00, 1'b1, "R8 only first step delivered");
    req_ready = 1'b1;
    wait_clk(2);
    chk(req_valid == 1'b0, "R8 valid drops after accept", req_valid, 0);
    drained("R8 later steps dropped");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule